// File: doc/BRIEF.md
# Colour Palette Register Block

This block holds a 256-entry colour lookup table. Each entry has separate 8-bit red, green and blue values. A processor loads it through a 32-bit write port that has two live word addresses. A write to offset 0x0 selects which entry to work on. Writes to offset 0x4 then deliver that entry's components one at a time: red first, then green, then blue. After the blue write the block moves on to the next entry by itself, so a whole palette can be streamed with one index write followed by a run of component writes.

A separate combinational lookup port serves the pixel path. It takes an entry number and returns the stored colour as 24 bits. After each component write, a one-cycle update pulse reports the entry number that was touched, so that downstream colour caches can refresh only that line. Bus reads of the register window always return zero.

Top module: `pal_dac`

## Requirements
- R1: After reset, entries 0 to 254 read on the lookup port as 24'h000000 and entry 255 reads as 24'hFFFFFF.
- R2: A write to offset 0x0 loads the working index from write data bits 31:24 and sets the component step to red.
- R3: Successive writes to offset 0x4 store write data bits 31:24 into the red, then the green, then the blue component of the entry at the working index. The new value is visible on the lookup port in the cycle after the write.
- R4: The blue write advances the working index by one modulo 256 (255 wraps to 0) and sets the step back to red.
- R5: `bus_rdata_o` is zero at all times.
- R6: Writes to any offset other than 0x0 and 0x4 change neither the palette, the index nor the step. Write data bits 23:0 have no effect.
- R7: Each component write makes `upd_valid_o` high for exactly the next cycle, with `upd_idx_o` set to the entry that was written. `upd_valid_o` stays low after index writes and after ignored writes.
- R8: The lookup port is combinational in `lut_idx_i`. In the cycle in which a component write is presented, the lookup returns the value from before the write.
- R9: Reset sets the working index to 0 and the step to red, so the first write to offset 0x4 after reset lands in red of entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 4 | Byte offset within the 16-byte window |
| bus_wdata_i | input | 32 | Write data; bits 31:24 are used |
| bus_rdata_o | output | 32 | Read data, always zero |
| lut_idx_i | input | 8 | Lookup entry number |
| lut_rgb_o | output | 24 | Lookup colour {R,G,B}, red in bits 23:16 |
| upd_valid_o | output | 1 | One-cycle pulse after each component write |
| upd_idx_o | output | 8 | Entry number of the last component write |

## Verification
The main table streams three components into one entry and then continues into the next entry. This shows whether the red, green and blue steps land in the right byte lanes and whether the auto-advance works. It then re-writes the index partway through an entry, which tells a true step reset apart from a step counter that only wraps. Writes to offsets 0x8 and 0xC are placed between component writes, so a decoder that treats them as data writes would shift every later component. Entry 255 is written in full to check the wrap to entry 0. Write data always carries a non-zero low 24-bit pattern, to catch a byte-lane slip. Separate directed cases sweep every entry after reset, catch the lookup in the same cycle as a write, and reset in mid-sequence.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned COMP_W = 8;
  localparam int unsigned IDX_W  = 8;
  localparam int unsigned N_COMP = 3;

  typedef enum logic [1:0] {
    STEP_RED = 2'd0,
    STEP_GRN = 2'd1,
    STEP_BLU = 2'd2
  } step_e;
endpackage

// File: rtl/pal_bus_decode.sv
module pal_bus_decode #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned IDX_OFF  = 0,
  parameter int unsigned COMP_OFF = 4
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              idx_we_o,
  output logic              comp_we_o
);
  localparam logic [ADDR_W-1:0] IdxAddr  = ADDR_W'(IDX_OFF);
  localparam logic [ADDR_W-1:0] CompAddr = ADDR_W'(COMP_OFF);

  assign idx_we_o  = we_i && (addr_i == IdxAddr);
  assign comp_we_o = we_i && (addr_i == CompAddr);
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_dac_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned N_COMP = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic [IDX_W-1:0]  idx_load_i,
  input  logic              comp_we_i,
  output logic [IDX_W-1:0]  cur_idx_o,
  output step_e             step_o,
  output logic [N_COMP-1:0] comp_sel_o
);
  logic [IDX_W-1:0] idx_q;
  step_e            step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      step_q <= STEP_RED;
    end else if (idx_we_i) begin
      idx_q  <= idx_load_i;
      step_q <= STEP_RED;
    end else if (comp_we_i) begin
      unique case (step_q)
        STEP_RED: step_q <= STEP_GRN;
        STEP_GRN: step_q <= STEP_BLU;
        default: begin
          step_q <= STEP_RED;
          idx_q  <= idx_q + 1'b1;
        end
      endcase
    end
  end

  // one-hot component enable, bit 0 = red
  always_comb begin
    comp_sel_o = '0;
    if (comp_we_i) begin
      unique case (step_q)
        STEP_RED: comp_sel_o[0] = 1'b1;
        STEP_GRN: comp_sel_o[1] = 1'b1;
        default:  comp_sel_o[N_COMP-1] = 1'b1;
      endcase
    end
  end

  assign cur_idx_o = idx_q;
  assign step_o    = step_q;
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned N_COMP = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_COMP-1:0]        wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [COMP_W-1:0]        wr_val_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  output logic [N_COMP*COMP_W-1:0] rd_rgb_o
);
  localparam int unsigned N_ENTRY = 1 << IDX_W;

  for (genvar c = 0; c < N_COMP; c++) begin : g_comp
    logic [COMP_W-1:0] mem_q [N_ENTRY];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int e = 0; e < N_ENTRY; e++)
          mem_q[e] <= (e == N_ENTRY - 1) ? {COMP_W{1'b1}} : '0;
      end else if (wr_en_i[c]) begin
        mem_q[wr_idx_i] <= wr_val_i;
      end
    end

    // component 0 (red) occupies the top lane
    assign rd_rgb_o[(N_COMP-c)*COMP_W-1 -: COMP_W] = mem_q[rd_idx_i];
  end
endmodule

// File: rtl/pal_dac.sv
module pal_dac
  import pal_dac_pkg::*;
#(
  parameter int unsigned DATA_W = pal_dac_pkg::DATA_W,
  parameter int unsigned ADDR_W = pal_dac_pkg::ADDR_W,
  parameter int unsigned COMP_W = pal_dac_pkg::COMP_W,
  parameter int unsigned IDX_W  = pal_dac_pkg::IDX_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_we_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [DATA_W-1:0]        bus_wdata_i,
  output logic [DATA_W-1:0]        bus_rdata_o,
  input  logic [IDX_W-1:0]         lut_idx_i,
  output logic [N_COMP*COMP_W-1:0] lut_rgb_o,
  output logic                     upd_valid_o,
  output logic [IDX_W-1:0]         upd_idx_o
);
  logic              idx_we, comp_we;
  logic [IDX_W-1:0]  cur_idx;
  step_e             step;
  logic [N_COMP-1:0] comp_sel;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata_i;

  pal_bus_decode #(
    .ADDR_W  (ADDR_W),
    .IDX_OFF (0),
    .COMP_OFF(4)
  ) u_dec (
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .idx_we_o (idx_we),
    .comp_we_o(comp_we)
  );

  pal_seq #(
    .IDX_W (IDX_W),
    .N_COMP(N_COMP)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_we_i  (idx_we),
    .idx_load_i(bus_wdata_i[DATA_W-1 -: IDX_W]),
    .comp_we_i (comp_we),
    .cur_idx_o (cur_idx),
    .step_o    (step),
    .comp_sel_o(comp_sel)
  );

  pal_store #(
    .IDX_W (IDX_W),
    .COMP_W(COMP_W),
    .N_COMP(N_COMP)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (comp_sel),
    .wr_idx_i(cur_idx),
    .wr_val_i(bus_wdata_i[DATA_W-1 -: COMP_W]),
    .rd_idx_i(lut_idx_i),
    .rd_rgb_o(lut_rgb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_valid_o <= 1'b0;
      upd_idx_o   <= '0;
    end else begin
      upd_valid_o <= comp_we;
      if (comp_we) upd_idx_o <= cur_idx;
    end
  end

  assign bus_rdata_o = '0;
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk
  import pal_dac_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned IDX_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              upd_valid_o,
  input logic [IDX_W-1:0]  upd_idx_o,
  input logic [IDX_W-1:0]  cur_idx,
  input step_e             step
);
  logic wr_idx, wr_comp, wr_other;
  assign wr_idx   = bus_we_i && (bus_addr_i == ADDR_W'(0));
  assign wr_comp  = bus_we_i && (bus_addr_i == ADDR_W'(4));
  assign wr_other = bus_we_i && !wr_idx && !wr_comp;

  p_rdata_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o == '0);

  p_index_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_idx |=> (cur_idx == $past(bus_wdata_i[DATA_W-1 -: IDX_W])) && (step == STEP_RED));

  p_blue_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_comp && step == STEP_BLU) |=> (cur_idx == IDX_W'($past(cur_idx) + 1'b1)) && (step == STEP_RED));

  p_ignore_other_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_other |=> $stable(cur_idx) && $stable(step));

  p_upd_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_comp |=> upd_valid_o && (upd_idx_o == $past(cur_idx)));

  p_upd_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_comp |=> !upd_valid_o);
endmodule

bind pal_dac pal_dac_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .upd_valid_o(upd_valid_o),
  .upd_idx_o  (upd_idx_o),
  .cur_idx    (cur_idx),
  .step       (step)
);

// File: tb/tb_pal_dac.sv
module tb_pal_dac;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [7:0]  lut_idx_i = '0;
  logic [23:0] lut_rgb_o;
  logic        upd_valid_o;
  logic [7:0]  upd_idx_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pal_dac dut (.*);

  always #10 clk_i = ~clk_i;

  typedef struct packed {
    logic [3:0]  addr;
    logic [7:0]  data;
    logic [7:0]  chk;
    logic [23:0] exp;
    logic        upd;
    logic [7:0]  uidx;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 8'h10, 8'h10, 24'h000000, 1'b0, 8'h00}, // R2 index 16
    '{4'h4, 8'hA1, 8'h10, 24'hA10000, 1'b1, 8'h10}, // R3 red
    '{4'h4, 8'hB2, 8'h10, 24'hA1B200, 1'b1, 8'h10}, // R3 green
    '{4'h4, 8'hC3, 8'h10, 24'hA1B2C3, 1'b1, 8'h10}, // R3 blue
    '{4'h4, 8'h11, 8'h11, 24'h110000, 1'b1, 8'h11}, // R4 advance
    '{4'h0, 8'h11, 8'h11, 24'h110000, 1'b0, 8'h00}, // R2 step back to red
    '{4'h4, 8'h22, 8'h11, 24'h220000, 1'b1, 8'h11}, // R2 red again
    '{4'h8, 8'h99, 8'h11, 24'h220000, 1'b0, 8'h00}, // R6 ignored
    '{4'h4, 8'h33, 8'h11, 24'h223300, 1'b1, 8'h11}, // R6 step kept
    '{4'hC, 8'h55, 8'h11, 24'h223300, 1'b0, 8'h00}, // R6 ignored
    '{4'h4, 8'h44, 8'h11, 24'h223344, 1'b1, 8'h11}, // R3 blue
    '{4'h0, 8'hFF, 8'hFF, 24'hFFFFFF, 1'b0, 8'h00}, // R2 index 255
    '{4'h4, 8'h01, 8'hFF, 24'h01FFFF, 1'b1, 8'hFF},
    '{4'h4, 8'h02, 8'hFF, 24'h0102FF, 1'b1, 8'hFF},
    '{4'h4, 8'h03, 8'hFF, 24'h010203, 1'b1, 8'hFF}, // R4 wrap
    '{4'h4, 8'h07, 8'h00, 24'h070000, 1'b1, 8'h00}  // R4 entry 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_we_i    = 1'b1;
    bus_addr_i  = a;
    bus_wdata_i = {d, 24'h5A3C96};
    @(negedge clk_i);
    bus_we_i = 1'b0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;

    // R1 reset contents, every entry
    for (int e = 0; e < 256; e++) begin
      lut_idx_i = 8'(e);
      #1;
      check("R1 reset entry", {8'h0, lut_rgb_o}, (e == 255) ? 32'hFFFFFF : 32'h0);
    end
    check("R7 no pulse after reset", {31'h0, upd_valid_o}, 32'h0);

    // main vector table
    for (int v = 0; v < NV; v++) begin
      lut_idx_i = VECS[v].chk;
      bus_write(VECS[v].addr, VECS[v].data);
      check("R3/R4/R6 lookup", {8'h0, lut_rgb_o}, {8'h0, VECS[v].exp});
      check("R7 pulse", {31'h0, upd_valid_o}, {31'h0, VECS[v].upd});
      if (VECS[v].upd) check("R7 pulse index", {24'h0, upd_idx_o}, {24'h0, VECS[v].uidx});
      check("R5 read zero", bus_rdata_o, 32'h0);
      @(negedge clk_i);
      #1;
      check("R7 single cycle", {31'h0, upd_valid_o}, 32'h0);
    end

    // R8 same-cycle lookup sees old value (entry 0 is at green step)
    @(negedge clk_i);
    lut_idx_i   = 8'h00;
    bus_we_i    = 1'b1;
    bus_addr_i  = 4'h4;
    bus_wdata_i = 32'h66_123456;
    #1;
    check("R8 old value same cycle", {8'h0, lut_rgb_o}, 32'h070000);
    @(negedge clk_i);
    bus_we_i = 1'b0;
    #1;
    check("R8 new value next cycle", {8'h0, lut_rgb_o}, 32'h076600);

    // R9 reset in mid-sequence
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 entry 0 cleared", {8'h0, lut_rgb_o}, 32'h0);
    lut_idx_i = 8'hFF;
    #1;
    check("R1 entry 255 white", {8'h0, lut_rgb_o}, 32'hFFFFFF);
    @(negedge clk_i);
    rst_ni = 1'b1;
    lut_idx_i = 8'h00;
    bus_write(4'h4, 8'h77);
    check("R9 first write red of entry 0", {8'h0, lut_rgb_o}, 32'h770000);
    check("R9 pulse index 0", {24'h0, upd_idx_o}, 32'h0);
    lut_idx_i = 8'h11;
    #1;
    check("R1 entry 17 cleared", {8'h0, lut_rgb_o}, 32'h0);

    finish_run();
  end
endmodule